// File: doc/BRIEF.md
# Infrared Serial Line Pulse Codec

This block sits between a UART serializer/deserializer and the two line pins of an infrared serial link. It turns the non-return-to-zero bit stream coming from the UART into short return-to-zero light pulses on the transmit pin. It also turns pulses seen on the receive pin back into a non-return-to-zero stream for the UART receiver. A 16x oversampling tick from the baud generator sets the bit timing.

With the enable low, both directions pass straight through. With it high, the transmit pin idles low. Every zero bit becomes one high pulse at the start of the bit, and every one bit leaves the line quiet. The pulse is either 3/16 of a bit or, in the low-power setting, exactly three periods of a slow clock made by dividing the system clock by an 8-bit prescaler. The receive pin idles high. A low pulse is qualified by its width in prescaler periods. The link is half-duplex, so reception is blocked while a transmission is under way.

Top module: `sir_codec`

## Requirements
- R1: With `sir_en` low, `pin_tx` equals `uart_txd` and `uart_rxd` equals `pin_rx` in the same cycle, with no register in either path.
- R2: With `sir_en` high, the idle levels are `pin_tx` = 0 and `uart_rxd` = 1. A cycle with `rst` high returns both outputs to these levels on the following edge, even in the middle of a pulse.
- R3: A frame starts at the first tick on which `uart_txd` is 0 while the encoder is idle. Bit boundaries then fall every 16 ticks. A zero bit gives exactly one pulse, which starts at the bit's first tick. A one bit gives no pulse.
- R4: With `lp_mode` low, each transmit pulse is high for exactly 3 tick intervals, from the bit's first tick edge to the third tick edge after it.
- R5: With `lp_mode` high, each transmit pulse is high for exactly 3 × `presc` clock cycles, counted from the bit's first tick edge.
- R6: A `presc` value of 0 acts as 1, for both the transmit pulse width and receive qualification.
- R7: After a two-flop synchronizer, a low on `pin_rx` that lasts `presc` consecutive cycles is accepted as a pulse. A shorter low is ignored and leaves `uart_rxd` at 1.
- R8: An accepted pulse drives `uart_rxd` low from the qualifying edge until 16 further tick edges have passed. A new accepted pulse reloads the full 16 ticks.
- R9: From the start of a frame until the encoder sees the 10th consecutive one bit, `uart_rxd` is held at 1 and pulses on `pin_rx` are discarded.
- R10: `lp_mode` has no effect on the receive path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sir_en | input | 1 | 1 = pulse coding, 0 = pass-through |
| lp_mode | input | 1 | 1 = prescaler-timed transmit pulses |
| presc | input | 8 | Slow-clock divider; 0 acts as 1 |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| uart_txd | input | 1 | NRZ transmit bit from the UART |
| pin_tx | output | 1 | Transmit line pin |
| pin_rx | input | 1 | Receive line pin |
| uart_rxd | output | 1 | NRZ receive bit to the UART |

## Verification
Frames are sent with a mixed pattern (0x35), all-zero data and all-one data. Comparing pulse counts across these frames shows whether the encoder reacts only to zero bits and whether frame start and bit boundaries stay aligned. Each frame is repeated with the prescaler at 5 and at 0, which separates tick-based pulse widths from prescaler-based ones and tests the zero-prescaler rule. On the receive side, lows one cycle shorter than the prescaler, exactly as long, back-to-back, and arriving during a transmission separate the rejection threshold, the retrigger rule and half-duplex blocking. A cycle-by-cycle behavioural model checks the exact timing of every edge throughout.

// File: rtl/sir_pkg.sv
package sir_pkg;

    localparam int OVS_TICKS  = 16;
    localparam int PH_W       = $clog2(OVS_TICKS);
    localparam int HOLD_W     = $clog2(OVS_TICKS + 1);
    localparam int NORM_TICKS = 3;
    localparam int LP_PERIODS = 3;
    localparam int LP_W       = $clog2(LP_PERIODS + 1);

    typedef enum logic [1:0] {
        PATH_THRU   = 2'd0,
        PATH_NORMAL = 2'd1,
        PATH_LOWPWR = 2'd2
    } tx_path_e;

    typedef struct packed {
        logic            act;
        logic            zero;
        logic [PH_W-1:0] phase;
    } enc_state_t;

    function automatic tx_path_e pick_path(input logic en, input logic lp);
        if (!en)
            return PATH_THRU;
        else if (lp)
            return PATH_LOWPWR;
        else
            return PATH_NORMAL;
    endfunction

endpackage

// File: rtl/sir_sync2.sv
module sir_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sir_tx_enc.sv
module sir_tx_enc
    import sir_pkg::*;
#(
    parameter int PRESC_W   = 8,
    parameter int IDLE_BITS = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               tick,
    input  logic               txd,
    input  logic [PRESC_W-1:0] presc,
    output logic               norm_pulse,
    output logic               lp_pulse,
    output logic               busy
);
    localparam int ONES_W = $clog2(IDLE_BITS + 1);

    logic [PRESC_W-1:0] div_eff;
    assign div_eff = (presc == '0) ? PRESC_W'(1) : presc;

    enc_state_t         st, st_n;
    logic [ONES_W-1:0]  ones, ones_n;
    logic               start_p;
    logic [LP_W-1:0]    lp_left;
    logic [PRESC_W-1:0] lp_pc;

    // Bit framing: phase counts ticks inside a bit
    always_comb begin
        st_n    = st;
        ones_n  = ones;
        start_p = 1'b0;
        if (tick) begin
            if (!st.act) begin
                if (!txd) begin
                    st_n.act   = 1'b1;
                    st_n.zero  = 1'b1;
                    st_n.phase = '0;
                    ones_n     = '0;
                    start_p    = 1'b1;
                end
            end else if (st.phase == PH_W'(OVS_TICKS - 1)) begin
                st_n.phase = '0;
                st_n.zero  = !txd;
                if (txd) begin
                    if (ones == ONES_W'(IDLE_BITS - 1)) begin
                        st_n.act  = 1'b0;
                        st_n.zero = 1'b0;
                        ones_n    = '0;
                    end else begin
                        ones_n = ones + ONES_W'(1);
                    end
                end else begin
                    ones_n  = '0;
                    start_p = 1'b1;
                end
            end else begin
                st_n.phase = st.phase + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st   <= '0;
            ones <= '0;
        end else begin
            st   <= st_n;
            ones <= ones_n;
        end
    end

    // Low-power pulse: own divider restarted at each pulse start
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            lp_left <= '0;
            lp_pc   <= '0;
        end else if (start_p) begin
            lp_left <= LP_W'(LP_PERIODS);
            lp_pc   <= '0;
        end else if (lp_left != '0) begin
            if (lp_pc == div_eff - PRESC_W'(1)) begin
                lp_pc   <= '0;
                lp_left <= lp_left - LP_W'(1);
            end else begin
                lp_pc <= lp_pc + PRESC_W'(1);
            end
        end
    end

    assign norm_pulse = st.act && st.zero && (st.phase < PH_W'(NORM_TICKS));
    assign lp_pulse   = (lp_left != '0);
    assign busy       = st.act;

    // R4
    pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(norm_pulse) |-> (st.phase == '0));

    // R5
    lp_count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (lp_left != '0 && !start_p) |=> (lp_left <= $past(lp_left)));

    // R9
    busy_only_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!txd));
endmodule

// File: rtl/sir_rx_dec.sv
module sir_rx_dec
    import sir_pkg::*;
#(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               busy,
    input  logic               tick,
    input  logic               rx_s,
    input  logic [PRESC_W-1:0] presc,
    output logic               nrz
);
    logic [PRESC_W-1:0] div_eff;
    logic [PRESC_W-1:0] wcnt;
    logic [HOLD_W-1:0]  ocnt;
    logic               accept;

    assign div_eff = (presc == '0) ? PRESC_W'(1) : presc;
    assign accept  = en && !busy && !rx_s && (wcnt == div_eff - PRESC_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en || busy) begin
            wcnt <= '0;
            ocnt <= '0;
        end else begin
            if (rx_s)
                wcnt <= '0;
            else if (wcnt != div_eff)
                wcnt <= wcnt + PRESC_W'(1);

            if (accept)
                ocnt <= HOLD_W'(OVS_TICKS);
            else if (tick && ocnt != '0)
                ocnt <= ocnt - HOLD_W'(1);
        end
    end

    assign nrz = (ocnt == '0);

    // R7
    accept_once_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!accept || !$stable(presc)));

    // R8
    hold_range_chk: assert property (@(posedge clk) disable iff (rst)
        ocnt <= HOLD_W'(OVS_TICKS));

    // R9
    busy_clears_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (ocnt == '0));
endmodule

// File: rtl/sir_codec.sv
module sir_codec
    import sir_pkg::*;
#(
    parameter int PRESC_W   = 8,
    parameter int IDLE_BITS = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sir_en,
    input  logic               lp_mode,
    input  logic [PRESC_W-1:0] presc,
    input  logic               tick16,
    input  logic               uart_txd,
    output logic               pin_tx,
    input  logic               pin_rx,
    output logic               uart_rxd
);
    tx_path_e path;
    logic     norm_pulse, lp_pulse, busy, rx_s, nrz;

    assign path = pick_path(sir_en, lp_mode);

    sir_tx_enc #(.PRESC_W(PRESC_W), .IDLE_BITS(IDLE_BITS)) u_enc (
        .clk        (clk),
        .rst        (rst),
        .en         (sir_en),
        .tick       (tick16),
        .txd        (uart_txd),
        .presc      (presc),
        .norm_pulse (norm_pulse),
        .lp_pulse   (lp_pulse),
        .busy       (busy)
    );

    sir_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_rx),
        .q   (rx_s)
    );

    sir_rx_dec #(.PRESC_W(PRESC_W)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .en    (sir_en),
        .busy  (busy),
        .tick  (tick16),
        .rx_s  (rx_s),
        .presc (presc),
        .nrz   (nrz)
    );

    always_comb begin
        case (path)
            PATH_NORMAL: pin_tx = norm_pulse;
            PATH_LOWPWR: pin_tx = lp_pulse;
            default:     pin_tx = uart_txd;
        endcase
    end

    assign uart_rxd = (path == PATH_THRU) ? pin_rx : (busy ? 1'b1 : nrz);

    // R2
    reset_tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && sir_en) |-> !pin_tx);

    // R2
    reset_rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && sir_en) |-> uart_rxd);
endmodule

// File: tb/sir_codec_test.sv
`timescale 1ns/1ps
module sir_codec_test;
    localparam int TDIV = 4;
    localparam int IDLE = 10;

    logic       clk = 1'b0, rst = 1'b1, sir_en = 1'b0, lp_mode = 1'b0;
    logic       uart_txd = 1'b1, pin_rx = 1'b1;
    logic [7:0] presc = 8'd4;
    logic       pin_tx, uart_rxd, tick;
    int         cyc = 0;

    int    n_tests = 0, n_fail = 0;
    bit    chk_on = 0, finished = 0;
    string cur_req = "R2";
    int    widths[$];
    int    run_w = 0, rx_low_cnt = 0;

    // model state
    bit m_act = 0, m_z = 0, m_rx1 = 1, m_rx2 = 1, m_start = 0, m_acc = 0;
    int m_t = 0, m_ones = 0, m_lp = 0, m_run = 0, m_hold = 0, m_p = 1;
    bit exp_tx, exp_rx;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign tick = ((cyc % TDIV) == 0);

    sir_codec uut (
        .clk(clk), .rst(rst), .sir_en(sir_en), .lp_mode(lp_mode), .presc(presc),
        .tick16(tick), .uart_txd(uart_txd), .pin_tx(pin_tx),
        .pin_rx(pin_rx), .uart_rxd(uart_rxd)
    );

    // behavioural reference
    always @(posedge clk) begin
        m_p = (presc == 0) ? 1 : presc;
        if (rst) begin
            m_rx1 = 1; m_rx2 = 1; m_run = 0; m_hold = 0;
            m_act = 0; m_z = 0; m_t = 0; m_ones = 0; m_lp = 0;
        end else begin
            if (!sir_en || m_act) begin
                m_run = 0; m_hold = 0;
            end else begin
                m_acc = 0;
                if (!m_rx2) begin
                    m_run++;
                    if (m_run == m_p) m_acc = 1;
                end else m_run = 0;
                if (m_acc) m_hold = 16;
                else if (tick && m_hold > 0) m_hold--;
            end
            m_rx2 = m_rx1;
            m_rx1 = pin_rx;
            m_start = 0;
            if (!sir_en) begin
                m_act = 0; m_z = 0; m_t = 0; m_ones = 0; m_lp = 0;
            end else begin
                if (tick) begin
                    if (!m_act) begin
                        if (!uart_txd) begin
                            m_act = 1; m_z = 1; m_t = 0; m_ones = 0; m_start = 1;
                        end
                    end else if (m_t == 15) begin
                        m_t = 0;
                        m_z = !uart_txd;
                        if (uart_txd) begin
                            m_ones++;
                            if (m_ones == IDLE) begin m_act = 0; m_z = 0; m_ones = 0; end
                        end else begin
                            m_ones = 0; m_start = 1;
                        end
                    end else m_t++;
                end
                if (m_start) m_lp = 3 * m_p;
                else if (m_lp > 0) m_lp--;
            end
        end
    end

    // per-cycle comparison and monitors, away from the edge
    always @(posedge clk) begin
        #5;
        if (chk_on) begin
            exp_tx = !sir_en ? uart_txd : (lp_mode ? (m_lp > 0) : (m_act && m_z && m_t < 3));
            exp_rx = !sir_en ? pin_rx : (m_act ? 1'b1 : (m_hold == 0));
            n_tests++;
            if (pin_tx !== exp_tx) begin
                n_fail++;
                $display("FAIL %s pin_tx actual=%0b expected=%0b at %0t", cur_req, pin_tx, exp_tx, $time);
            end
            n_tests++;
            if (uart_rxd !== exp_rx) begin
                n_fail++;
                $display("FAIL %s uart_rxd actual=%0b expected=%0b at %0t", cur_req, uart_rxd, exp_rx, $time);
            end
        end
        if (sir_en && pin_tx) run_w++;
        else if (run_w > 0) begin widths.push_back(run_w); run_w = 0; end
        if (sir_en && !uart_rxd) rx_low_cnt++;
    end

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic next_tick();
        do @(negedge clk); while (tick !== 1'b1);
    endtask

    task automatic send_frame(input logic [7:0] b);
        logic [9:0] bits;
        bits = {1'b1, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            next_tick();
            uart_txd = bits[i];
            repeat (15) next_tick();
        end
        repeat ((IDLE + 1) * 16) next_tick();
    endtask

    task automatic pulse_rx(input int len);
        pin_rx = 1'b0;
        repeat (len) @(negedge clk);
        pin_rx = 1'b1;
    endtask

    task automatic check_widths(input string req, input int cnt, input int w);
        check(req, widths.size() == cnt, widths.size(), cnt);
        foreach (widths[i]) check(req, widths[i] == w, widths[i], w);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        sir_en = 1'b1;
        chk_on = 1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset levels
        check("R2", pin_tx == 1'b0, pin_tx, 0);
        check("R2", uart_rxd == 1'b1, uart_rxd, 1);

        // R1 pass-through
        cur_req = "R1";
        sir_en = 1'b0; uart_txd = 1'b0;
        @(negedge clk); check("R1", pin_tx == 1'b0, pin_tx, 0);
        uart_txd = 1'b1;
        @(negedge clk); check("R1", pin_tx == 1'b1, pin_tx, 1);
        pin_rx = 1'b0;
        @(negedge clk); check("R1", uart_rxd == 1'b0, uart_rxd, 0);
        pin_rx = 1'b1;
        @(negedge clk); check("R1", uart_rxd == 1'b1, uart_rxd, 1);

        // R3 / R4 normal pulses, mixed byte: 5 zero bits
        cur_req = "R4";
        sir_en = 1'b1; lp_mode = 1'b0;
        repeat (5) @(negedge clk);
        widths.delete();
        send_frame(8'h35);
        check_widths("R4", 5, 3 * TDIV);

        // R3 all ones: only the start bit pulses
        cur_req = "R3";
        widths.delete();
        send_frame(8'hFF);
        check_widths("R3", 1, 3 * TDIV);

        // R3 all zeros: nine pulses
        widths.delete();
        send_frame(8'h00);
        check_widths("R3", 9, 3 * TDIV);

        // R5 low-power width
        cur_req = "R5";
        lp_mode = 1'b1; presc = 8'd5;
        widths.delete();
        send_frame(8'h35);
        check_widths("R5", 5, 15);

        // R6 prescaler zero acts as one
        cur_req = "R6";
        presc = 8'd0;
        widths.delete();
        send_frame(8'h35);
        check_widths("R6", 5, 3);

        // R2 reset in the middle of a pulse
        cur_req = "R2";
        lp_mode = 1'b0; presc = 8'd4;
        uart_txd = 1'b0;
        next_tick();
        @(negedge clk);
        check("R3", pin_tx == 1'b1, pin_tx, 1);
        rst = 1'b1; uart_txd = 1'b1;
        @(negedge clk);
        check("R2", pin_tx == 1'b0, pin_tx, 0);
        check("R2", uart_rxd == 1'b1, uart_rxd, 1);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        // R7 qualification threshold
        cur_req = "R7";
        rx_low_cnt = 0;
        pulse_rx(3);
        repeat (20) @(negedge clk);
        check("R7", rx_low_cnt == 0, rx_low_cnt, 0);
        cur_req = "R8";
        rx_low_cnt = 0;
        pulse_rx(4);
        repeat (80) @(negedge clk);
        check("R8", rx_low_cnt >= 61 && rx_low_cnt <= 64, rx_low_cnt, 64);

        // R8 retrigger
        rx_low_cnt = 0;
        pulse_rx(4);
        repeat (30) @(negedge clk);
        pulse_rx(4);
        repeat (100) @(negedge clk);
        check("R8", rx_low_cnt >= 90 && rx_low_cnt <= 100, rx_low_cnt, 96);

        // R6 decoder with prescaler zero
        cur_req = "R6";
        presc = 8'd0;
        repeat (4) @(negedge clk);
        rx_low_cnt = 0;
        pulse_rx(1);
        repeat (80) @(negedge clk);
        check("R6", rx_low_cnt >= 61 && rx_low_cnt <= 64, rx_low_cnt, 64);

        // R10 low-power setting leaves the decoder alone
        cur_req = "R10";
        presc = 8'd4; lp_mode = 1'b1;
        repeat (4) @(negedge clk);
        rx_low_cnt = 0;
        pulse_rx(3);
        repeat (20) @(negedge clk);
        check("R10", rx_low_cnt == 0, rx_low_cnt, 0);
        pulse_rx(4);
        repeat (80) @(negedge clk);
        check("R10", rx_low_cnt >= 61 && rx_low_cnt <= 64, rx_low_cnt, 64);

        // R9 half-duplex blocking
        cur_req = "R9";
        lp_mode = 1'b0;
        rx_low_cnt = 0;
        fork
            send_frame(8'h00);
            begin
                repeat (100) @(negedge clk);
                pulse_rx(20);
                repeat (200) @(negedge clk);
                pulse_rx(30);
            end
        join
        check("R9", rx_low_cnt == 0, rx_low_cnt, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule